// File: doc/BRIEF.md
# Seeded Fetch Memory Responder

This block stands in for the memory behind an instruction cache during verification. It has no storage. Each word it returns is a fixed 32-bit mix of the word address and a 32-bit seed. Two kinds of error come from an address window that is derived arithmetically from that seed: a protection fault and a memory fault.

A fetch goes through three steps. The cache strobes a request address. The block then reports a protection fault at once or grants the request after a programmable wait. Each granted request gets one in-order response a fixed number of cycles after its grant. A nonzero seed offered with the strobe replaces the running seed, and only at that moment. The seed is stored with the request and travels with it through the response pipeline, so every check for one fetch uses one seed, even when a later request loads a new seed before the earlier response has come out.

Top module: `fetch_mem_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, prot_err, gnt, rvalid and rerr are low and rdata is zero. The running seed starts at RESET_SEED (default 0).
- R2: A strobe is accepted only while the block is idle. The block is idle when no request is awaiting a decision or a grant, and it is idle again in the cycle where the prot_err or gnt pulse is visible. At acceptance a nonzero seed_in replaces the running seed and a zero seed_in keeps it. Strobes and seed_in values offered while the block is busy have no effect.
- R3: An accepted request that hits the protection check produces a one-cycle prot_err pulse two cycles after the strobe cycle. That request is never granted.
- R4: An accepted request that passes the protection check produces a one-cycle gnt pulse 3 + D cycles after the strobe cycle. D is cfg_gnt_dly, sampled at acceptance.
- R5: Each grant produces exactly one one-cycle rvalid pulse, exactly RESP_LAT cycles after the gnt pulse. Responses come out in grant order.
- R6: rdata is taken from a little-endian concatenation of consecutive words. The concatenation starts at word address addr[31:2] and contains BUS_W/32+1 words. It is shifted right by 8·addr[1:0] and truncated to BUS_W bits. Each word is mix(x), where x = {2'b00, word address} XOR seed and mix is: x ^= x>>16; x *= 0x7FEB352D; x ^= x>>15; x *= 0x846CA68B; x ^= x>>16 (all in 32 bits).
- R7: When the memory check hits, the response has rerr high and rdata all zeros. rerr is never high without rvalid.
- R8: The window for a seed s runs from lo = s XOR 0xDEADBEEF to hi = lo + min(0x20000000, 0xFFFFFFFF − lo). A check value a hits when a < hi and lo < a + BUS_W/8, with all arithmetic in 32 bits and wrapping. The protection check uses a = addr XOR 0x12344321. The memory check uses a = addr XOR 0xF00DBEEF.
- R9: When cfg_pmp_en is low, the protection check never hits; it is sampled in the cycle after the strobe. When cfg_mem_en is low, the memory check never hits; it is sampled in the cycle before rvalid.
- R10: Each response uses the seed latched when its own request was accepted, even when a later request has loaded a different seed before that response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pmp_en | input | 1 | Enable for the protection check |
| cfg_mem_en | input | 1 | Enable for the memory check |
| cfg_gnt_dly | input | DLY_W | Extra wait cycles before a grant |
| seed_in | input | 32 | New seed offered with a strobe; zero keeps the current seed |
| req_stb | input | 1 | One-cycle request strobe |
| req_addr | input | 32 | Byte address of the request |
| prot_err | output | 1 | Protection fault pulse for the accepted request |
| gnt | output | 1 | Grant pulse for the accepted request |
| rvalid | output | 1 | Response valid pulse |
| rdata | output | BUS_W | Response data |
| rerr | output | 1 | Memory fault flag of the response |

## Verification
Some properties are checked on every cycle: grant and fault pulses last exactly one cycle, a grant never follows a protection fault within two cycles, and no response comes out unless a grant is outstanding. In addition, a faulted response carries zero data, and a fault of either kind only appears when its enable was set in the cycle where it is sampled. Other behaviour can only be shown by the bench's scenarios. These are the exact window edges, including the wrap at the top of the address space and the clipped window. They also include the hash data for misaligned addresses, the exact grant and response cycles, the busy-time strobes that must be ignored, and a seed change that overtakes a response still in flight.

// File: rtl/fmr_pkg.sv
`timescale 1ns/1ps
package fmr_pkg;

  localparam logic [31:0] WIN_KEY  = 32'hDEADBEEF;
  localparam logic [31:0] PROT_KEY = 32'h12344321;
  localparam logic [31:0] MEM_KEY  = 32'hF00DBEEF;
  localparam logic [31:0] WIN_MAX  = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] seed;
  } fetch_tag_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_DECIDE,
    FS_WAIT
  } front_state_e;

  // Seeded window test: [a, a+nbytes) against [lo, hi), 32-bit wrapping arithmetic
  function automatic logic win_hit(logic [31:0] seed, logic [31:0] a, logic [31:0] nbytes);
    logic [31:0] lo, room, hi;
    lo   = seed ^ WIN_KEY;
    room = 32'hFFFF_FFFF - lo;
    hi   = lo + ((WIN_MAX < room) ? WIN_MAX : room);
    return (a < hi) && (lo < (a + nbytes));
  endfunction

  // Two xorshift-multiply rounds
  function automatic logic [31:0] mix32(logic [31:0] x);
    logic [31:0] h;
    h = x;
    h = h ^ (h >> 16);
    h = h * 32'h7FEB352D;
    h = h ^ (h >> 15);
    h = h * 32'h846CA68B;
    h = h ^ (h >> 16);
    return h;
  endfunction

endpackage

// File: rtl/fmr_front.sv
`timescale 1ns/1ps
module fmr_front
  import fmr_pkg::*;
#(
  parameter int          DLY_W      = 4,
  parameter int          NBYTES     = 4,
  parameter logic [31:0] RESET_SEED = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_stb,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      seed_in,
  input  logic             cfg_pmp_en,
  input  logic [DLY_W-1:0] cfg_gnt_dly,
  output logic             prot_err,
  output logic             gnt,
  output fetch_tag_t       gnt_tag
);

  localparam logic [31:0] NB = 32'(NBYTES);

  front_state_e     st_q;
  fetch_tag_t       tag_q;
  logic [31:0]      cur_seed_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  logic             perr_q;
  logic             gnt_q;

  logic [31:0] pick_seed;
  logic        prot_hit;

  assign pick_seed = (seed_in != 32'h0) ? seed_in : cur_seed_q;
  assign prot_hit  = cfg_pmp_en && win_hit(tag_q.seed, tag_q.addr ^ PROT_KEY, NB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FS_IDLE;
      tag_q      <= '0;
      cur_seed_q <= RESET_SEED;
      dly_q      <= '0;
      cnt_q      <= '0;
      perr_q     <= 1'b0;
      gnt_q      <= 1'b0;
    end else begin
      perr_q <= 1'b0;
      gnt_q  <= 1'b0;
      case (st_q)
        FS_IDLE: begin
          if (req_stb) begin
            tag_q      <= '{addr: req_addr, seed: pick_seed};
            cur_seed_q <= pick_seed;
            dly_q      <= cfg_gnt_dly;
            st_q       <= FS_DECIDE;
          end
        end
        FS_DECIDE: begin
          if (prot_hit) begin
            perr_q <= 1'b1;
            st_q   <= FS_IDLE;
          end else begin
            cnt_q <= '0;
            st_q  <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (cnt_q == dly_q) begin
            gnt_q <= 1'b1;
            st_q  <= FS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign prot_err = perr_q;
  assign gnt      = gnt_q;
  assign gnt_tag  = tag_q;

endmodule

// File: rtl/fmr_resp_pipe.sv
`timescale 1ns/1ps
module fmr_resp_pipe
  import fmr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  fetch_tag_t in_tag,
  output logic       out_vld,
  output fetch_tag_t out_tag
);

  logic       vld_q [STAGES];
  fetch_tag_t tag_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic       src_vld;
    fetch_tag_t src_tag;
    if (g == 0) begin : g_head
      assign src_vld = in_vld;
      assign src_tag = in_tag;
    end else begin : g_body
      assign src_vld = vld_q[g-1];
      assign src_tag = tag_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) vld_q[g] <= 1'b0;
      else     vld_q[g] <= src_vld;
    end

    always_ff @(posedge clk) begin
      if (src_vld) tag_q[g] <= src_tag;
    end
  end

  assign out_vld = vld_q[STAGES-1];
  assign out_tag = tag_q[STAGES-1];

endmodule

// File: rtl/fmr_word_gen.sv
`timescale 1ns/1ps
module fmr_word_gen
  import fmr_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             cfg_mem_en,
  input  fetch_tag_t       tag,
  output logic [BUS_W-1:0] data,
  output logic             err
);

  localparam int          NW = BUS_W / 32 + 1;
  localparam logic [31:0] NB = 32'(BUS_W / 8);

  logic [29:0]      wbase;
  logic [NW*32-1:0] cat;
  logic [4:0]       shamt;

  assign wbase = tag.addr[31:2];
  assign shamt = {tag.addr[1:0], 3'b000};

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign cat[i*32 +: 32] = mix32({2'b00, wbase + 30'(i)} ^ tag.seed);
  end

  assign err  = cfg_mem_en && win_hit(tag.seed, tag.addr ^ MEM_KEY, NB);
  assign data = err ? '0 : BUS_W'(cat >> shamt);

endmodule

// File: rtl/fetch_mem_responder.sv
`timescale 1ns/1ps
module fetch_mem_responder
  import fmr_pkg::*;
#(
  parameter int          BUS_W      = 32,
  parameter int          DLY_W      = 4,
  parameter int          RESP_LAT   = 3,
  parameter logic [31:0] RESET_SEED = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_pmp_en,
  input  logic             cfg_mem_en,
  input  logic [DLY_W-1:0] cfg_gnt_dly,
  input  logic [31:0]      seed_in,
  input  logic             req_stb,
  input  logic [31:0]      req_addr,
  output logic             prot_err,
  output logic             gnt,
  output logic             rvalid,
  output logic [BUS_W-1:0] rdata,
  output logic             rerr
);

  localparam int STAGES = (RESP_LAT > 1) ? RESP_LAT - 1 : 1;

  fetch_tag_t       gnt_tag;
  logic             p_vld;
  fetch_tag_t       p_tag;
  logic [BUS_W-1:0] w_data;
  logic             w_err;

  fmr_front #(
    .DLY_W     (DLY_W),
    .NBYTES    (BUS_W / 8),
    .RESET_SEED(RESET_SEED)
  ) u_front (
    .clk        (clk),
    .rst        (rst),
    .req_stb    (req_stb),
    .req_addr   (req_addr),
    .seed_in    (seed_in),
    .cfg_pmp_en (cfg_pmp_en),
    .cfg_gnt_dly(cfg_gnt_dly),
    .prot_err   (prot_err),
    .gnt        (gnt),
    .gnt_tag    (gnt_tag)
  );

  fmr_resp_pipe #(
    .STAGES(STAGES)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .in_vld (gnt),
    .in_tag (gnt_tag),
    .out_vld(p_vld),
    .out_tag(p_tag)
  );

  fmr_word_gen #(
    .BUS_W(BUS_W)
  ) u_word (
    .cfg_mem_en(cfg_mem_en),
    .tag       (p_tag),
    .data      (w_data),
    .err       (w_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rerr   <= 1'b0;
    end else begin
      rvalid <= p_vld;
      rdata  <= p_vld ? w_data : '0;
      rerr   <= p_vld && w_err;
    end
  end

endmodule

// File: rtl/fetch_mem_responder_chk.sv
`timescale 1ns/1ps
module fetch_mem_responder_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_pmp_en,
  input logic             cfg_mem_en,
  input logic             prot_err,
  input logic             gnt,
  input logic             rvalid,
  input logic [BUS_W-1:0] rdata,
  input logic             rerr
);

  logic [7:0] owed_q;

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_q + 8'(gnt) - 8'(rvalid);
  end

  AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !gnt);                                             // R4
  AST_PERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> !prot_err);                                   // R3
  AST_NO_GNT_AFTER_PERR: assert property (@(posedge clk) disable iff (rst)
    gnt |-> !$past(prot_err) && !$past(prot_err, 2));          // R3
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    prot_err |-> $past(cfg_pmp_en));                           // R9
  AST_MERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rerr) |-> $past(cfg_mem_en));                   // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rerr) |-> (rdata == '0));                       // R7
  AST_ERR_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> !rerr);                                        // R7
  AST_RESP_OWED: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (owed_q != 8'd0));                              // R5

endmodule

bind fetch_mem_responder fetch_mem_responder_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_pmp_en(cfg_pmp_en),
  .cfg_mem_en(cfg_mem_en),
  .prot_err  (prot_err),
  .gnt       (gnt),
  .rvalid    (rvalid),
  .rdata     (rdata),
  .rerr      (rerr)
);

// File: tb/fetch_mem_responder_bench.sv
`timescale 1ns/1ps
module fetch_mem_responder_bench;

  localparam int DLY_W    = 4;
  localparam int RESP_LAT = 3;
  localparam logic [1:0] K_OK = 2'd0, K_PERR = 2'd1, K_MERR = 2'd2;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] addr;
    logic [3:0]  dly;
    logic [1:0]  kind;
  } vec_t;

  // Window edges for seeds DEADBEEF (lo=0), 9EADBEEF (lo=40000000), 2EADBEEF (clipped, lo=F0000000)
  localparam vec_t VECS [13] = '{
    '{32'hDEADBEEF, 32'h40001000, 4'd0,  K_OK},
    '{32'h00000000, 32'h00000100, 4'd1,  K_PERR},
    '{32'h00000000, 32'hF0000004, 4'd2,  K_MERR},
    '{32'h00000000, 32'h80000002, 4'd0,  K_OK},
    '{32'h12345678, 32'h00000040, 4'd3,  K_OK},
    '{32'h00000000, 32'h00000043, 4'd0,  K_OK},
    '{32'h9EADBEEF, 32'h2DCBBCDD, 4'd0,  K_OK},
    '{32'h00000000, 32'h2DCBBCDC, 4'd0,  K_PERR},
    '{32'h00000000, 32'h4DCBBCDE, 4'd4,  K_PERR},
    '{32'h00000000, 32'h72344321, 4'd0,  K_OK},
    '{32'h2EADBEEF, 32'h0FF24111, 4'd15, K_OK},
    '{32'h00000000, 32'h0FF2411F, 4'd0,  K_MERR},
    '{32'h00000000, 32'h1FF24113, 4'd2,  K_OK}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_pmp_en = 1'b1;
  logic             cfg_mem_en = 1'b1;
  logic [DLY_W-1:0] cfg_gnt_dly = '0;
  logic [31:0]      seed_in = '0;
  logic             req_stb = 1'b0;
  logic [31:0]      req_addr = '0;
  logic             prot_err, gnt, rvalid, rerr;
  logic [31:0]      rdata;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          cyc      = 0;
  logic [31:0] m_seed   = 32'h0;

  int          q_due  [$];
  logic [31:0] q_data [$];
  logic        q_err  [$];
  string       q_req  [$];

  fetch_mem_responder #(
    .BUS_W(32), .DLY_W(DLY_W), .RESP_LAT(RESP_LAT), .RESET_SEED(32'h0)
  ) u_fetch_mem_responder (
    .clk(clk), .rst(rst), .cfg_pmp_en(cfg_pmp_en), .cfg_mem_en(cfg_mem_en),
    .cfg_gnt_dly(cfg_gnt_dly), .seed_in(seed_in), .req_stb(req_stb),
    .req_addr(req_addr), .prot_err(prot_err), .gnt(gnt), .rvalid(rvalid),
    .rdata(rdata), .rerr(rerr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mix_m(logic [31:0] x);
    logic [31:0] h = x;
    h = h ^ (h >> 16);
    h = h * 32'h7FEB352D;
    h = h ^ (h >> 15);
    h = h * 32'h846CA68B;
    h = h ^ (h >> 16);
    return h;
  endfunction

  function automatic logic [31:0] data_m(logic [31:0] s, logic [31:0] a);
    logic [29:0] wa = a[31:2];
    logic [63:0] cat = {mix_m({2'b00, wa + 30'd1} ^ s), mix_m({2'b00, wa} ^ s)};
    return 32'(cat >> (8 * a[1:0]));
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // Response scoreboard (R5 timing, R6 data, R7 error flag)
  always @(negedge clk) begin
    if (!rst) begin
      if (q_due.size() != 0 && cyc > q_due[0]) begin
        chk(1'b0, {q_req[0], " R5 response missing"}, 64'(cyc), 64'(q_due[0]));
        void'(q_due.pop_front()); void'(q_data.pop_front());
        void'(q_err.pop_front()); void'(q_req.pop_front());
      end
      if (rvalid) begin
        if (q_due.size() == 0) begin
          chk(1'b0, "R5 unexpected rvalid", 64'(cyc), 64'(0));
        end else begin
          chk(cyc == q_due[0], {q_req[0], " R5 response cycle"}, 64'(cyc), 64'(q_due[0]));
          chk(rdata == q_data[0], {q_req[0], " R6 data"}, 64'(rdata), 64'(q_data[0]));
          chk(rerr == q_err[0], {q_req[0], " R7 error flag"}, 64'(rerr), 64'(q_err[0]));
          void'(q_due.pop_front()); void'(q_data.pop_front());
          void'(q_err.pop_front()); void'(q_req.pop_front());
        end
      end
    end
  end

  // Drive one strobe at the current negedge; optionally poke a second strobe while busy.
  task automatic issue(input logic [31:0] s, input logic [31:0] a, input int d,
                       input logic [1:0] kind, input string rq,
                       input bit poke, input logic [31:0] poke_seed, input logic [31:0] poke_addr);
    int  c0 = cyc;
    int  due;
    bit  early = 1'b0;
    req_stb = 1'b1; req_addr = a; seed_in = s; cfg_gnt_dly = DLY_W'(d);
    if (s != 32'h0) m_seed = s;
    @(negedge clk);
    if (poke) begin req_stb = 1'b1; req_addr = poke_addr; seed_in = poke_seed; end
    else      begin req_stb = 1'b0; seed_in = '0; end
    due = (kind == K_PERR) ? c0 + 2 : c0 + 3 + d;
    while (cyc < due) begin
      if (prot_err || gnt) early = 1'b1;
      @(negedge clk);
      req_stb = 1'b0; seed_in = '0;
    end
    chk(!early, {rq, " R2 no outcome before due cycle"}, 64'(early), 64'(0));
    chk(prot_err == (kind == K_PERR), {rq, " R3 R8 protection outcome"}, 64'(prot_err), 64'(kind == K_PERR));
    chk(gnt == (kind != K_PERR), {rq, " R4 grant outcome"}, 64'(gnt), 64'(kind != K_PERR));
    if (kind != K_PERR) begin
      q_due.push_back(due + RESP_LAT);
      q_data.push_back((kind == K_MERR) ? 32'h0 : data_m(m_seed, a));
      q_err.push_back(kind == K_MERR);
      q_req.push_back(rq);
    end
  endtask

  task automatic drain();
    repeat (RESP_LAT + 20) @(negedge clk);
    chk(q_due.size() == 0, "R5 all responses delivered", 64'(q_due.size()), 64'(0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    chk(prot_err == 1'b0 && gnt == 1'b0, "R1 front outputs in reset", 64'({prot_err, gnt}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk({prot_err, gnt, rvalid, rerr} == 4'b0, "R1 flags after reset", 64'({prot_err, gnt, rvalid, rerr}), 64'(0));
    chk(rdata == 32'h0, "R1 rdata after reset", 64'(rdata), 64'(0));

    // R1: reset seed 0 is in use before any load
    issue(32'h0, 32'h40000000, 0, K_OK, "R1 reset seed", 1'b0, '0, '0);

    // Table walk: R3 R4 R6 R7 R8 and back-to-back seed changes (R10)
    for (int i = 0; i < 13; i++) begin
      issue(VECS[i].seed, VECS[i].addr, int'(VECS[i].dly), VECS[i].kind,
            $sformatf("R8 vec%0d", i), 1'b0, '0, '0);
    end
    drain();

    // R2: strobe with new seed during decide is ignored; later data still uses DEADBEEF
    issue(32'hDEADBEEF, 32'h40001000, 3, K_OK, "R2 busy poke", 1'b1, 32'h55555555, 32'h00000100);
    issue(32'h0, 32'h80000002, 0, K_OK, "R2 seed kept", 1'b0, '0, '0);
    drain();

    // R10: new seed accepted in the grant cycle while the older response is in flight
    issue(32'hDEADBEEF, 32'h40001000, 0, K_OK, "R10 older", 1'b0, '0, '0);
    issue(32'h12345678, 32'h00000040, 0, K_OK, "R10 newer", 1'b0, '0, '0);
    drain();

    // R9: protection check disabled
    cfg_pmp_en = 1'b0;
    issue(32'hDEADBEEF, 32'h00000100, 1, K_OK, "R9 pmp off", 1'b0, '0, '0);
    cfg_pmp_en = 1'b1;
    drain();

    // R9: memory check disabled
    cfg_mem_en = 1'b0;
    issue(32'h0, 32'hF0000004, 0, K_OK, "R9 mem off", 1'b0, '0, '0);
    drain();
    cfg_mem_en = 1'b1;

    // R7: the same address faults again once enabled
    issue(32'h0, 32'hF0000004, 0, K_MERR, "R7 mem on", 1'b0, '0, '0);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule